// File: doc/BRIEF.md
# Reset Control and Interrupt Flag Register

This block is a single 8-bit software-visible register together with the logic that builds the system reset. It latches three interrupt events: an alarm, a supply-voltage supervisor and a coprocessor watchdog. Each event raises a sticky flag on the rising edge of its source. Software clears a flag by writing 1 to its bit. If that source is still active at the time of the clear, the flag is not cleared. It is parked in a blocked state, where it still reads as set but no longer drives the interrupt line and ignores new edges. A later clear, made while the source is inactive, clears the flag and arms it again.

The same register holds five control levels: I2C output enable, DCO input clamp, clock source select (PLL or DCO), internal reset disable, and a write-only bit that pulls the shared active-low reset line. The system reset output is the OR of three terms: the external reset pin after synchronization, the internal reset requests unless disabled, and the block's own drive of the line. The output rises in the same cycle as any request. It falls only after a fixed number of clock edges with no request present.

Top module: `rstctl_top`

## Requirements
- R1: After the synchronous reset the register reads 0x08. The DCO clamp output is 1, the I2C enable and clock select outputs are 0, the reset line output is high and the interrupt output is 0.
- R2: A write loads the control bits from fixed positions: bit 4 is I2C enable, bit 3 is DCO clamp, bit 2 is clock select (1 = PLL) and bit 1 is reset disable. Each bit reads back at the same position, and the first three bits drive their outputs.
- R3: Bit 0 is write-only and always reads 0. Writing 1 to it drives `rst_line_n_o` low, and writing 0 releases the line high.
- R4: A rising edge on an armed source sets its flag after one clock edge. The alarm flag is at bit 7, the supply flag at bit 6 and the watchdog flag at bit 5. The sources arrive on `irq_src_i[2]`, `[1]` and `[0]` in that order.
- R5: Writing 1 to a set flag while its source is low clears the flag. Writing 0 to a flag leaves it unchanged.
- R6: Writing 1 to a set flag while its source is high leaves the flag reading 1 and blocks it. A blocked flag does not drive `irq_o`, and later rising edges of its source have no effect.
- R7: A blocked flag is cleared by a write of 1 made while its source is low. After that clear, the next rising edge sets the flag and drives `irq_o` again.
- R8: `irq_o` is the OR of the flags that are set and not blocked.
- R9: A low level on `ext_rst_n_i` asserts `sys_rst_o` after two clock edges and keeps it asserted while the low level lasts.
- R10: Any bit of `int_rst_req_i` asserts `sys_rst_o` in the same cycle, unless the reset-disable bit is 1. With reset disable set, the internal requests have no effect.
- R11: `sys_rst_o` is released two clock edges after the last active source is removed, and it is asserted during the block's own reset.
- R12: While bit 0 is set, `sys_rst_o` is asserted, in the same way as for an external reset on the shared line.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register read value |
| irq_src_i | input | 3 | Interrupt sources: [2] alarm, [1] supply, [0] watchdog |
| irq_o | output | 1 | Combined interrupt to the controller |
| ext_rst_n_i | input | 1 | External active-low reset pin level |
| int_rst_req_i | input | 2 | Internal reset requests, active high |
| i2c_en_o | output | 1 | I2C output enable |
| dco_clamp_o | output | 1 | DCO input clamp |
| clk_sel_pll_o | output | 1 | Clock source select, 1 = PLL |
| rst_line_n_o | output | 1 | Drive level for the shared reset line, active low |
| sys_rst_o | output | 1 | Combined system reset, active high |

## Verification
All 16 combinations of the four read-write control bits are written and read back. This tells apart a swapped or missing field from a correct decode, and it confirms that no control write disturbs the reset output. Each of the three sources is taken through the same sequence: set, write 0, blocked clear, edge while blocked, successful clear, re-armed edge, ordinary clear. This sequence separates a plain write-1-to-clear flag from one that blocks and re-arms. The sources are also combined to show the interrupt OR. The three reset paths (external pin, internal request with and without the disable bit, and the self-drive bit) are each timed edge by edge on assertion and release, so that an extra or missing register stage is caught.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_FLAGS  = 3;

    // Field positions inside the register; software depends on them.
    localparam int BIT_ALARM  = 7;
    localparam int BIT_SUPPLY = 6;
    localparam int BIT_WDOG   = 5;
    localparam int BIT_I2C    = 4;
    localparam int BIT_DCO    = 3;
    localparam int BIT_CLK    = 2;
    localparam int BIT_RDIS   = 1;
    localparam int BIT_ROUT   = 0;
    localparam int FLAG_LSB   = BIT_WDOG;
    localparam int FLAG_MSB   = FLAG_LSB + NUM_FLAGS - 1;

    typedef struct packed {
        logic i2c_en;
        logic dco_clamp;
        logic clk_pll;
        logic rst_dis;
        logic rst_out;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        i2c_en:    1'b0,
        dco_clamp: 1'b1,
        clk_pll:   1'b0,
        rst_dis:   1'b0,
        rst_out:   1'b0
    };

    function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] d);
        ctrl_t c;
        c.i2c_en    = d[BIT_I2C];
        c.dco_clamp = d[BIT_DCO];
        c.clk_pll   = d[BIT_CLK];
        c.rst_dis   = d[BIT_RDIS];
        c.rst_out   = d[BIT_ROUT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input logic [NUM_FLAGS-1:0] f,
                                                   input ctrl_t c);
        logic [REG_W-1:0] r;
        r                    = '0;
        r[FLAG_MSB:FLAG_LSB] = f;
        r[BIT_I2C]           = c.i2c_en;
        r[BIT_DCO]           = c.dco_clamp;
        r[BIT_CLK]           = c.clk_pll;
        r[BIT_RDIS]          = c.rst_dis;
        r[BIT_ROUT]          = 1'b0;   // write-only bit
        return r;
    endfunction

endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstctl_irq_flag.sv
module rstctl_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic clr_i,
    output logic flag_o,
    output logic active_o
);
    logic src_q;
    logic flag_q;
    logic armed_q;
    logic rise;
    logic set_now;
    logic pend;

    always_comb begin
        rise    = src_i & ~src_q;
        set_now = rise & armed_q;
        pend    = flag_q | set_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= 1'b0;
            flag_q  <= 1'b0;
            armed_q <= 1'b1;
        end else begin
            src_q <= src_i;
            if (clr_i && pend) begin
                if (src_i) begin
                    flag_q  <= 1'b1;   // clear refused, park blocked
                    armed_q <= 1'b0;
                end else begin
                    flag_q  <= 1'b0;
                    armed_q <= 1'b1;
                end
            end else if (set_now) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign flag_o   = flag_q;
    assign active_o = flag_q & armed_q;

    p_set_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (src_i && !src_q && armed_q) |=> flag_q);

    p_clear_ok_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !src_i) |=> !flag_q);

    p_clear_blocked_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && src_i && flag_q) |=> (flag_q && !armed_q));

    p_blocked_is_set_r6: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> flag_q);

    p_stay_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !clr_i) |=> !armed_q);
endmodule

// File: rtl/rstctl_reset_comb.sv
module rstctl_reset_comb #(
    parameter int NUM_INT_REQ    = 2,
    parameter int SYNC_STAGES    = 2,
    parameter int RELEASE_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ext_rst_n_i,
    input  logic [NUM_INT_REQ-1:0] int_req_i,
    input  logic                   rst_dis_i,
    input  logic                   rst_out_i,
    output logic                   sys_rst_o
);
    logic                      ext_n_sync;
    logic                      raw_req;
    logic [RELEASE_STAGES-1:0] hold_q;

    rstctl_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_ext_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_rst_n_i),
        .q_o (ext_n_sync)
    );

    always_comb begin
        raw_req = ~ext_n_sync | ((|int_req_i) & ~rst_dis_i) | rst_out_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '1;
        end else begin
            hold_q[0] <= raw_req;
            for (int i = 1; i < RELEASE_STAGES; i++) begin
                hold_q[i] <= hold_q[i-1];
            end
        end
    end

    assign sys_rst_o = raw_req | (|hold_q);

    p_release_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> !$past(raw_req));

    p_hold_after_req_r11: assert property (@(posedge clk) disable iff (rst)
        raw_req |=> sys_rst_o);
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int NUM_INT_REQ    = 2,
    parameter int SYNC_STAGES    = 2,
    parameter int RELEASE_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en_i,
    input  logic [REG_W-1:0]       wdata_i,
    output logic [REG_W-1:0]       rd_data_o,
    input  logic [NUM_FLAGS-1:0]   irq_src_i,
    output logic                   irq_o,
    input  logic                   ext_rst_n_i,
    input  logic [NUM_INT_REQ-1:0] int_rst_req_i,
    output logic                   i2c_en_o,
    output logic                   dco_clamp_o,
    output logic                   clk_sel_pll_o,
    output logic                   rst_line_n_o,
    output logic                   sys_rst_o
);
    ctrl_t                ctrl_q;
    logic [NUM_FLAGS-1:0] flag_w;
    logic [NUM_FLAGS-1:0] active_w;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= CTRL_RESET;
        else if (wr_en_i) ctrl_q <= decode_ctrl(wdata_i);
    end

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        rstctl_irq_flag u_flag (
            .clk      (clk),
            .rst      (rst),
            .src_i    (irq_src_i[k]),
            .clr_i    (wr_en_i & wdata_i[FLAG_LSB + k]),
            .flag_o   (flag_w[k]),
            .active_o (active_w[k])
        );
    end

    rstctl_reset_comb #(
        .NUM_INT_REQ    (NUM_INT_REQ),
        .SYNC_STAGES    (SYNC_STAGES),
        .RELEASE_STAGES (RELEASE_STAGES)
    ) u_comb (
        .clk         (clk),
        .rst         (rst),
        .ext_rst_n_i (ext_rst_n_i),
        .int_req_i   (int_rst_req_i),
        .rst_dis_i   (ctrl_q.rst_dis),
        .rst_out_i   (ctrl_q.rst_out),
        .sys_rst_o   (sys_rst_o)
    );

    assign rd_data_o     = pack_read(flag_w, ctrl_q);
    assign irq_o         = |active_w;
    assign i2c_en_o      = ctrl_q.i2c_en;
    assign dco_clamp_o   = ctrl_q.dco_clamp;
    assign clk_sel_pll_o = ctrl_q.clk_pll;
    assign rst_line_n_o  = ~ctrl_q.rst_out;

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (rd_data_o[BIT_I2C:BIT_RDIS] == $past(wdata_i[BIT_I2C:BIT_RDIS])));

    p_line_follows_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (rst_line_n_o == !$past(wdata_i[BIT_ROUT])));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (rd_data_o[FLAG_MSB:FLAG_LSB] != '0));
endmodule

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rd;
    logic [2:0] src = '0;
    logic       irq;
    logic       ext_n = 1'b1;
    logic [1:0] ireq = '0;
    logic       i2c, dco, clkp, line_n, srst;
    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rstctl_top dut_i (
        .clk (clk), .rst (rst), .wr_en_i (wr_en), .wdata_i (wdata),
        .rd_data_o (rd), .irq_src_i (src), .irq_o (irq),
        .ext_rst_n_i (ext_n), .int_rst_req_i (ireq),
        .i2c_en_o (i2c), .dco_clamp_o (dco), .clk_sel_pll_o (clkp),
        .rst_line_n_o (line_n), .sys_rst_o (srst)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1;
        wdata = v;
        tick();
        wr_en = 1'b0;
        wdata = '0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk({7'd0, srst}, 8'd1, "R11 asserted in reset");
        rst = 1'b0;
        chk(rd, 8'h08, "R1 read value");
        chk({4'd0, i2c, dco, clkp, line_n}, 8'b0101, "R1 outputs");
        chk({7'd0, irq}, 8'd0, "R1 irq");
        tick();
        chk({7'd0, srst}, 8'd1, "R11 one edge after reset");
        tick();
        chk({7'd0, srst}, 8'd0, "R11 released after reset");

        // R2: sweep every control combination
        for (int v = 0; v < 16; v++) begin
            wr(8'(v << 1));
            chk(rd, 8'(v << 1), "R2 readback");
            chk({5'd0, i2c, dco, clkp}, 8'(v >> 1), "R2 outputs");
            chk({7'd0, srst}, 8'd0, "R2 no reset");
        end
        wr(8'h08);

        // R3 / R12: self drive of the reset line
        wr(8'h09);
        chk(rd, 8'h08, "R3 bit0 reads 0");
        chk({7'd0, line_n}, 8'd0, "R3 line driven");
        chk({7'd0, srst}, 8'd1, "R12 own drive resets");
        wr(8'h08);
        chk({7'd0, line_n}, 8'd1, "R3 line released");
        tick();
        chk({7'd0, srst}, 8'd1, "R11 hold after drive");
        tick();
        chk({7'd0, srst}, 8'd0, "R11 release after drive");

        // R10: internal requests
        ireq = 2'b01;
        #1;
        chk({7'd0, srst}, 8'd1, "R10 same cycle");
        tick();
        ireq = 2'b00;
        tick();
        chk({7'd0, srst}, 8'd1, "R11 hold after internal");
        tick();
        chk({7'd0, srst}, 8'd0, "R11 release after internal");
        wr(8'h0A);
        ireq = 2'b10;
        tick();
        chk({7'd0, srst}, 8'd0, "R10 disabled");
        tick();
        chk({7'd0, srst}, 8'd0, "R10 disabled later");
        ireq = 2'b00;
        wr(8'h08);

        // R9: external pin through synchronizer
        ext_n = 1'b0;
        tick();
        chk({7'd0, srst}, 8'd0, "R9 first edge");
        tick();
        chk({7'd0, srst}, 8'd1, "R9 second edge");
        repeat (3) tick();
        chk({7'd0, srst}, 8'd1, "R9 held low");
        ext_n = 1'b1;
        for (int t = 1; t <= 4; t++) begin
            tick();
            chk({7'd0, srst}, (t < 4) ? 8'd1 : 8'd0, "R11 external release");
        end

        // R4..R8 per source
        for (int k = 0; k < 3; k++) begin
            logic [7:0] fb;
            fb = 8'(1 << (5 + k));
            src[k] = 1'b1;
            tick();
            chk(rd, 8'h08 | fb, "R4 flag set");
            chk({7'd0, irq}, 8'd1, "R8 irq on");
            wr(8'h08);
            chk(rd, 8'h08 | fb, "R5 write 0 no effect");
            wr(8'h08 | fb);
            chk(rd, 8'h08 | fb, "R6 blocked clear");
            chk({7'd0, irq}, 8'd0, "R6 blocked no irq");
            src[k] = 1'b0;
            tick();
            src[k] = 1'b1;
            tick();
            chk(rd, 8'h08 | fb, "R6 still set");
            chk({7'd0, irq}, 8'd0, "R6 edge suppressed");
            src[k] = 1'b0;
            tick();
            wr(8'h08 | fb);
            chk(rd, 8'h08, "R7 clear after drop");
            chk({7'd0, irq}, 8'd0, "R7 irq off");
            src[k] = 1'b1;
            tick();
            chk(rd, 8'h08 | fb, "R7 rearmed");
            chk({7'd0, irq}, 8'd1, "R7 irq again");
            src[k] = 1'b0;
            tick();
            wr(8'h08 | fb);
            chk(rd, 8'h08, "R5 clear");
        end

        // R8: combination of flags
        src = 3'b111;
        tick();
        chk(rd, 8'hE8, "R8 all flags");
        src = 3'b000;
        tick();
        wr(8'h88);
        chk(rd, 8'h68, "R5 single clear");
        chk({7'd0, irq}, 8'd1, "R8 remaining flags");
        wr(8'h68);
        chk(rd, 8'h08, "R5 clear rest");
        chk({7'd0, irq}, 8'd0, "R8 none left");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule